// File: doc/BRIEF.md
# Loop Counter Branch Unit

This block carries out the counted-loop branch primitive of a small processor core. A single control byte tells it what to do with one register: step it down by one, step it up by one, or leave it as it is. It also says whether the branch should be taken when the result is zero or when it is nonzero, gives the ninth (sign) bit of the branch offset, and names the register. The block reads that register through a read port and computes the stepped value. It writes the value back through a write port whether or not the branch is taken. It also reports the branch decision with the target address.

The core presents the control byte, the offset byte that follows it and the program counter together with a one-cycle `start` strobe. The program counter is already advanced past both bytes. One clock later every result is registered and valid for one cycle. Instruction fetch and the register storage sit outside the block.

Top module: `loop_branch_unit`

## Requirements
- R1: While `rst_n` is low, and after reset until the first `start`, `res_valid`, `branch_taken`, `wr_en` and `illegal_op` are low.
- R2: Control byte bits 7:6 pick the step: 2'b00 subtracts one, 2'b01 adds zero (test only), 2'b10 adds one. Arithmetic wraps at the register width.
- R3: Bits 7:6 equal to 2'b11 raise `illegal_op` for one cycle, with `wr_en` and `branch_taken` low.
- R4: Bit 5 = 1 takes the branch when the stepped value is nonzero. Bit 5 = 0 takes it when the stepped value is zero.
- R5: `branch_target` equals `pc` plus the 9-bit two's-complement offset {bit 4, offset byte}, sign-extended and wrapping at the address width.
- R6: Bits 2:0 name the register: 0=A, 1=B, 2=CCR, 3=scratch, 4=D, 5=X, 6=Y, 7=SP. `rd_sel` and the registered `wr_sel` carry this code.
- R7: For a legal step, `wr_en` is high with the stepped value on `wr_data` whether or not the branch is taken.
- R8: For codes 0, 1 and 2 (8-bit registers), only the low 8 bits of `rd_data` are stepped and tested for zero. `wr_data` carries the 8-bit result with its upper bits zero.
- R9: Results appear exactly one clock after a `start` cycle, with `res_valid` high for that one cycle only. Back-to-back `start` cycles give back-to-back results.
- R10: Control byte bit 3 has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle strobe: operands valid this cycle |
| postbyte | input | 8 | Control byte (step, sense, offset sign, register) |
| offset_byte | input | 8 | Low 8 bits of the branch offset |
| pc | input | ADDR_W | Program counter past both bytes |
| rd_sel | output | 3 | Register read select, combinational from `postbyte` |
| rd_data | input | DATA_W | Register read data for `rd_sel` |
| res_valid | output | 1 | Results valid this cycle |
| branch_taken | output | 1 | Branch decision |
| branch_target | output | ADDR_W | Branch destination |
| wr_en | output | 1 | Register write strobe |
| wr_sel | output | 3 | Register write select |
| wr_data | output | DATA_W | Stepped register value |
| illegal_op | output | 1 | Reserved step code seen |

## Verification
The bench builds the block with its default parameters: a 16-bit address and 16-bit registers over an 8-bit narrow view. At these widths the wrap cases are easy to reach. A backward offset from a low `pc` wraps below zero, incrementing 0xFFFF wraps to zero, and decrementing an 8-bit register that holds zero in its low byte must give 0xFF rather than 0xFFFF. Garbage placed in the upper byte of A, B or CCR shows whether the narrow zero test ignores it.

// File: rtl/lcb_pkg.sv
package lcb_pkg;

  typedef enum logic [1:0] {
    STEP_DEC = 2'b00,
    STEP_TST = 2'b01,
    STEP_INC = 2'b10,
    STEP_BAD = 2'b11
  } step_e;

  typedef enum logic [2:0] {
    RS_A   = 3'd0,
    RS_B   = 3'd1,
    RS_CC  = 3'd2,
    RS_TMP = 3'd3,
    RS_D   = 3'd4,
    RS_X   = 3'd5,
    RS_Y   = 3'd6,
    RS_SP  = 3'd7
  } rsel_e;

  typedef struct packed {
    step_e step;
    logic  on_nonzero;
    logic  off_sign;
    rsel_e rsel;
  } ctl_t;

  // Registers narrower than the full datapath (codes below RS_TMP)
  function automatic logic is_narrow(rsel_e s);
    return (s == RS_A) || (s == RS_B) || (s == RS_CC);
  endfunction

endpackage

// File: rtl/lcb_decode.sv
module lcb_decode
  import lcb_pkg::*;
(
  input  logic [7:0] postbyte,
  output ctl_t       ctl,
  output logic       bad_step
);

  // Bit 3 of the control byte carries no meaning and is not decoded.
  always_comb begin
    ctl.step       = step_e'(postbyte[7:6]);
    ctl.on_nonzero = postbyte[5];
    ctl.off_sign   = postbyte[4];
    ctl.rsel       = rsel_e'(postbyte[2:0]);
  end

  assign bad_step = (ctl.step == STEP_BAD);

endmodule

// File: rtl/lcb_update.sv
module lcb_update
  import lcb_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8
) (
  input  ctl_t              ctl,
  input  logic [DATA_W-1:0] cur,
  output logic [DATA_W-1:0] nxt,
  output logic              nxt_zero,
  output logic              take
);

  localparam int HI_W = DATA_W - BYTE_W;

  function automatic logic [DATA_W-1:0] step_amount(step_e s);
    case (s)
      STEP_DEC: return {DATA_W{1'b1}};
      STEP_INC: return {{(DATA_W-1){1'b0}}, 1'b1};
      default:  return '0;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] narrow_add(logic [DATA_W-1:0] a,
                                                   logic [DATA_W-1:0] b);
    logic [BYTE_W-1:0] lo;
    lo = a[BYTE_W-1:0] + b[BYTE_W-1:0];
    return {{HI_W{1'b0}}, lo};
  endfunction

  logic [DATA_W-1:0] amount;
  logic [DATA_W-1:0] wide_sum;
  logic [DATA_W-1:0] thin_sum;
  logic              use_thin;

  assign amount   = step_amount(ctl.step);
  assign wide_sum = cur + amount;
  assign thin_sum = narrow_add(cur, amount);
  assign use_thin = is_narrow(ctl.rsel);
  assign nxt      = use_thin ? thin_sum : wide_sum;
  assign nxt_zero = (nxt == '0);
  assign take     = ctl.on_nonzero ? !nxt_zero : nxt_zero;

endmodule

// File: rtl/lcb_target.sv
module lcb_target #(
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] pc,
  input  logic              off_sign,
  input  logic [7:0]        off_byte,
  output logic [ADDR_W-1:0] target
);

  localparam int EXT_W = ADDR_W - 9;

  function automatic logic [ADDR_W-1:0] widen_offset(logic s, logic [7:0] b);
    return {{EXT_W{s}}, s, b};
  endfunction

  assign target = pc + widen_offset(off_sign, off_byte);

endmodule

// File: rtl/loop_branch_unit.sv
module loop_branch_unit
  import lcb_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [7:0]        postbyte,
  input  logic [7:0]        offset_byte,
  input  logic [ADDR_W-1:0] pc,
  output logic [2:0]        rd_sel,
  input  logic [DATA_W-1:0] rd_data,
  output logic              res_valid,
  output logic              branch_taken,
  output logic [ADDR_W-1:0] branch_target,
  output logic              wr_en,
  output logic [2:0]        wr_sel,
  output logic [DATA_W-1:0] wr_data,
  output logic              illegal_op
);

  ctl_t              ctl;
  logic              bad_step;
  logic [DATA_W-1:0] next_val;
  logic              next_zero;
  logic              take_cond;
  logic [ADDR_W-1:0] tgt;
  logic              legal_start;
  logic              r_on_nonzero;

  lcb_decode u_decode (
    .postbyte (postbyte),
    .ctl      (ctl),
    .bad_step (bad_step)
  );

  lcb_update #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_update (
    .ctl      (ctl),
    .cur      (rd_data),
    .nxt      (next_val),
    .nxt_zero (next_zero),
    .take     (take_cond)
  );

  lcb_target #(.ADDR_W(ADDR_W)) u_target (
    .pc       (pc),
    .off_sign (ctl.off_sign),
    .off_byte (offset_byte),
    .target   (tgt)
  );

  assign rd_sel      = ctl.rsel;
  assign legal_start = start && !bad_step;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid     <= 1'b0;
      branch_taken  <= 1'b0;
      wr_en         <= 1'b0;
      illegal_op    <= 1'b0;
      branch_target <= '0;
      wr_sel        <= '0;
      wr_data       <= '0;
      r_on_nonzero  <= 1'b0;
    end else begin
      res_valid    <= start;
      illegal_op   <= start && bad_step;
      wr_en        <= legal_start;
      branch_taken <= legal_start && take_cond;
      if (start) begin
        branch_target <= tgt;
        wr_sel        <= ctl.rsel;
        wr_data       <= next_val;
        r_on_nonzero  <= ctl.on_nonzero;
      end
    end
  end

  function automatic logic [DATA_W-1:0] view_of(logic [2:0] s, logic [DATA_W-1:0] v);
    return is_narrow(rsel_e'(s)) ? {{(DATA_W-BYTE_W){1'b0}}, v[BYTE_W-1:0]} : v;
  endfunction

  AST_START_GIVES_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> res_valid); // R9
  AST_RESULT_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(start)); // R9
  AST_WRITE_OR_ILLEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (wr_en != illegal_op)); // R7
  AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_op |-> (!branch_taken && !wr_en)); // R3
  AST_TAKEN_HAS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    branch_taken |-> wr_en); // R7
  AST_NARROW_UPPER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && is_narrow(rsel_e'(wr_sel))) |-> (wr_data[DATA_W-1:BYTE_W] == '0)); // R8
  AST_SENSE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (branch_taken == (r_on_nonzero ? (wr_data != '0) : (wr_data == '0)))); // R4
  AST_TEST_KEEPS_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    (start && postbyte[7:6] == 2'b01) |=> (wr_data == view_of($past(postbyte[2:0]), $past(rd_data)))); // R2
  AST_SELECT_CARRIED: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (wr_sel == $past(postbyte[2:0]))); // R6

endmodule

// File: tb/loop_branch_unit_tb.sv
`timescale 1ns/1ps
module loop_branch_unit_tb;

  localparam int AW = 16;
  localparam int DW = 16;

  typedef struct packed {
    logic          illegal;
    logic          taken;
    logic [AW-1:0] target;
    logic [2:0]    wsel;
    logic [DW-1:0] wdata;
    int            due;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [7:0]    postbyte = '0;
  logic [7:0]    offset_byte = '0;
  logic [AW-1:0] pc = '0;
  logic [2:0]    rd_sel;
  logic [DW-1:0] rd_data;
  logic          res_valid, branch_taken, wr_en, illegal_op;
  logic [AW-1:0] branch_target;
  logic [2:0]    wr_sel;
  logic [DW-1:0] wr_data;

  logic [DW-1:0] rf [8];
  assign rd_data = rf[rd_sel];

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit armed  = 1'b0;
  exp_t  exp_q[$];
  string tag_q[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  loop_branch_unit u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .postbyte(postbyte),
    .offset_byte(offset_byte), .pc(pc), .rd_sel(rd_sel), .rd_data(rd_data),
    .res_valid(res_valid), .branch_taken(branch_taken),
    .branch_target(branch_target), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .illegal_op(illegal_op)
  );

  task automatic note(bit ok, string tag, string what, longint act, longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, expv);
    end
  endtask

  // Driver: holds start for one cycle and queues the expected result
  task automatic issue(logic [7:0] pb, logic [7:0] off, logic [AW-1:0] pcv,
                       logic [DW-1:0] regv, string tag);
    exp_t e;
    int delta, offs, nv;
    bit narrow, zero;
    @(negedge clk);
    rf[pb[2:0]] = regv;
    postbyte = pb; offset_byte = off; pc = pcv; start = 1'b1;
    narrow = (pb[2:0] <= 3'd2);
    delta  = (pb[7:6] == 2'b00) ? -1 : (pb[7:6] == 2'b10) ? 1 : 0;
    if (narrow) nv = (int'(regv) % 256 + delta + 256) % 256;
    else        nv = (int'(regv) + delta + 65536) % 65536;
    zero   = (nv == 0);
    offs   = pb[4] ? int'(off) - 256 : int'(off);
    e.illegal = (pb[7:6] == 2'b11);
    e.taken   = !e.illegal && (pb[5] ? !zero : zero);
    e.target  = AW'((int'(pcv) + offs + 65536) % 65536);
    e.wsel    = pb[2:0];
    e.wdata   = DW'(nv);
    e.due     = cyc + 1;
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      start = 1'b0;
    end
  endtask

  // Monitor: compares at the falling edge, when the result is due
  always @(negedge clk) begin
    if (armed) begin
      if (exp_q.size() > 0 && exp_q[0].due == cyc) begin
        exp_t e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        note(res_valid, t, "res_valid", res_valid, 1);
        note(illegal_op == e.illegal, t, "illegal_op", illegal_op, e.illegal);
        note(branch_taken == e.taken, t, "branch_taken", branch_taken, e.taken);
        note(wr_en == !e.illegal, t, "wr_en", wr_en, !e.illegal);
        if (!e.illegal) begin
          note(branch_target == e.target, t, "branch_target", branch_target, e.target);
          note(wr_sel == e.wsel, t, "wr_sel", wr_sel, e.wsel);
          note(wr_data == e.wdata, t, "wr_data", wr_data, e.wdata);
        end
      end else begin
        // R9: no result outside the cycle after a start
        note(!res_valid && !wr_en && !branch_taken && !illegal_op, "R9", "idle outputs",
             {res_valid, wr_en, branch_taken, illegal_op}, 0);
      end
    end
  end

  initial begin
    #100000;
    fails++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) rf[i] = '0;
    repeat (3) @(negedge clk);
    // R1: outputs quiet in reset
    note(!res_valid && !branch_taken && !wr_en && !illegal_op, "R1", "in reset",
         {res_valid, branch_taken, wr_en, illegal_op}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    note(!res_valid && !branch_taken && !wr_en && !illegal_op, "R1", "after reset",
         {res_valid, branch_taken, wr_en, illegal_op}, 0);
    armed = 1'b1;

    // R2/R4: decrement X 5 -> 4, branch on nonzero, forward offset
    issue(8'b00_1_0_0_101, 8'h10, 16'h1000, 16'h0005, "R2"); idle(2);
    // R7: decrement X 1 -> 0, branch on nonzero not taken, still written
    issue(8'b00_1_0_0_101, 8'h10, 16'h1000, 16'h0001, "R7"); idle(2);
    // R4: decrement D 1 -> 0, branch on zero taken
    issue(8'b00_0_0_0_100, 8'h04, 16'h2000, 16'h0001, "R4"); idle(2);
    // R2: increment Y 0xFFFF wraps to 0, branch on zero
    issue(8'b10_0_0_0_110, 8'h02, 16'h3000, 16'hFFFF, "R2"); idle(2);
    // R2: test SP, value kept, branch on nonzero
    issue(8'b01_1_0_0_111, 8'h20, 16'h4000, 16'h1234, "R2"); idle(2);
    // R8: test A with garbage upper byte, low byte zero -> zero
    issue(8'b01_0_0_0_000, 8'h08, 16'h5000, 16'h1200, "R8"); idle(2);
    // R8: decrement B 0x3400 -> 0x00FF
    issue(8'b00_1_0_0_001, 8'h08, 16'h5000, 16'h3400, "R8"); idle(2);
    // R8: increment CCR 0x00FF -> 0x0000
    issue(8'b10_0_0_0_010, 8'h08, 16'h5000, 16'h00FF, "R8"); idle(2);
    // R6: scratch register is full width, 0x0100 - 1 = 0x00FF
    issue(8'b00_1_0_0_011, 8'h01, 16'h6000, 16'h0100, "R6"); idle(2);
    // R5: backward offset -128 wraps below zero
    issue(8'b00_1_1_0_101, 8'h80, 16'h0040, 16'h0009, "R5"); idle(2);
    // R5: most negative offset -256
    issue(8'b00_1_1_0_100, 8'h00, 16'h0300, 16'h0009, "R5"); idle(2);
    // R10: bit 3 set changes nothing
    issue(8'b00_1_0_1_101, 8'h10, 16'h1000, 16'h0005, "R10"); idle(2);
    issue(8'b10_0_1_1_001, 8'h33, 16'h0100, 16'h00FF, "R10"); idle(2);
    // R3: reserved step code
    issue(8'b11_1_0_0_101, 8'h10, 16'h1000, 16'h0005, "R3"); idle(2);
    // R6: every register code, decrementing 0x0180
    for (int s = 0; s < 8; s++) begin
      issue({5'b00_1_0_0, 3'(s)}, 8'h05, 16'h0800, 16'h0180, "R6");
      idle(1);
    end
    // R9: back-to-back starts
    issue(8'b00_1_0_0_101, 8'h01, 16'h0010, 16'h0003, "R9");
    issue(8'b10_0_0_0_110, 8'h02, 16'h0020, 16'h0007, "R9");
    issue(8'b11_0_0_0_100, 8'h03, 16'h0030, 16'h0000, "R9");
    issue(8'b01_0_1_0_000, 8'hFF, 16'h0040, 16'h0000, "R9");
    idle(4);

    note(exp_q.size() == 0, "R9", "results outstanding", exp_q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule